// File: doc/BRIEF.md
# Entropy Conditioner with Bias Monitor

This block turns the raw outputs of several free-running entropy sources into a debiased bit stream. Each source input is first brought into the clock domain through a two-stage synchronizer. Whenever the sampling strobe is high on a clock edge, the synchronized sources are folded by exclusive-OR into one raw bit.

The raw bits then feed two consumers in parallel. A pairwise debiaser groups the raw bits two at a time, with no overlap between pairs. It emits one output bit for each unequal pair and nothing for an equal pair, so the output rate varies with the input statistics. A health monitor counts the ones in consecutive fixed windows of raw bits. It raises a sticky alarm when a window's count drifts too far from half the window. While the alarm is up, the output stream is withheld until software pulses the clear input.

Top module: `trng_cond`

## Requirements
- R1: After reset, `out_valid` and `alarm` are 0, the debiaser holds no pending bit, and the window counters start at sample zero.
- R2: Each source input passes through two flops before use. A raw sample is taken only on a clock edge where `sample_stb` is 1, and its value is the XOR of all synchronized sources. Source activity without a strobe produces no output and no window progress.
- R3: Raw samples are grouped into consecutive non-overlapping pairs: 1st+2nd, 3rd+4th, and so on. An equal pair (00 or 11) produces no output.
- R4: An unequal pair produces exactly one output bit equal to the first bit of the pair: first 1 then 0 gives 1, first 0 then 1 gives 0. `out_valid` is high for one cycle, on the cycle after the edge that captured the pair's second sample.
- R5: The monitor counts ones over windows of 2^WIN_LOG2 raw samples. With mid = 2^(WIN_LOG2-1) and tol = ceil(173·2^WIN_LOG2/10000), the alarm is set when a window's count is below mid−tol or above mid+tol. The alarm becomes visible in the same cycle as a debiaser output from that window's last sample.
- R6: The alarm is sticky. A 1 on `clear_alarm` at a clock edge drops it, except that a window failing at that same edge sets it and the set wins.
- R7: While `alarm` is 1, `out_valid` stays 0. Pairing and window counting continue underneath.
- R8: `clear_alarm` does not restart the current window or the current pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_stb | input | 1 | Take one raw sample at this edge |
| src_in | input | NSRC | Asynchronous entropy source bits |
| clear_alarm | input | 1 | Drops a raised alarm |
| out_valid | output | 1 | Debiased bit present this cycle |
| out_bit | output | 1 | Debiased bit value |
| alarm | output | 1 | Sticky bias alarm |

## Verification
The bench builds the block with three sources and a 16-sample window. With these values the tolerance is one, so counts of 7, 8 and 9 pass and every other count trips the alarm. This makes both boundary counts and clear failures reachable in a few hundred cycles. Every raw bit is driven through a rotating source pattern, so all eight 3-bit source combinations reach the XOR fold. Windows are built with chosen ones counts, including 0 and 16.

// File: rtl/trng_pkg.sv
package trng_pkg;

  // Allowed deviation from half a window: ceil(0.0173 * 2^n)
  function automatic int unsigned bias_tol(input int unsigned n);
    int unsigned prod;
    prod = 173 * (32'd1 << n);
    return (prod + 9999) / 10000;
  endfunction

  // 1 when a window's ones count lies inside the accepted band
  function automatic logic count_ok(input int unsigned ones, input int unsigned n);
    int unsigned mid;
    int unsigned tol;
    mid = 32'd1 << (n - 1);
    tol = bias_tol(n);
    return (ones + tol >= mid) && (ones <= mid + tol);
  endfunction

  // Fold of all sampled sources into one raw bit
  function automatic logic fold_xor(input logic [31:0] v, input int unsigned w);
    logic r;
    r = 1'b0;
    for (int i = 0; i < 32; i++)
      if (i < int'(w)) r = r ^ v[i];
    return r;
  endfunction

  typedef struct packed {
    logic vld;
    logic bit_v;
  } raw_s;

endpackage

// File: rtl/trng_sync.sv
module trng_sync #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] d_in,
  output logic [NSRC-1:0] q_out
);
  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_bit
      logic s1_q, s2_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          s1_q <= 1'b0;
          s2_q <= 1'b0;
        end else begin
          s1_q <= d_in[g];
          s2_q <= s1_q;
        end
      end
      assign q_out[g] = s2_q;
    end
  endgenerate
endmodule

// File: rtl/trng_sampler.sv
module trng_sampler
  import trng_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stb,
  input  logic [NSRC-1:0] src_sync,
  output raw_s            raw
);
  logic [31:0] wide;
  always_comb begin
    wide = '0;
    wide[NSRC-1:0] = src_sync;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw <= '0;
    end else begin
      raw.vld   <= stb;
      raw.bit_v <= stb ? fold_xor(wide, NSRC) : raw.bit_v;
    end
  end
endmodule

// File: rtl/trng_debias.sv
module trng_debias
  import trng_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  raw_s raw,
  output logic vn_vld,
  output logic vn_bit
);
  logic have_q, first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_q  <= 1'b0;
      first_q <= 1'b0;
      vn_vld  <= 1'b0;
      vn_bit  <= 1'b0;
    end else begin
      vn_vld <= 1'b0;
      if (raw.vld) begin
        if (have_q) begin
          have_q <= 1'b0;
          if (first_q != raw.bit_v) begin
            vn_vld <= 1'b1;
            vn_bit <= first_q;
          end
        end else begin
          have_q  <= 1'b1;
          first_q <= raw.bit_v;
        end
      end
    end
  end
endmodule

// File: rtl/trng_health.sv
module trng_health
  import trng_pkg::*;
#(
  parameter int WIN_LOG2 = 12
) (
  input  logic clk,
  input  logic rst,
  input  raw_s raw,
  input  logic clr,
  output logic win_end,
  output logic alarm_q
);
  localparam int CW = WIN_LOG2 + 1;

  logic [WIN_LOG2-1:0] idx_q;
  logic [CW-1:0]       ones_q;
  logic [CW-1:0]       ones_nx;
  logic                fail;

  assign ones_nx = ones_q + CW'(raw.bit_v);
  assign win_end = raw.vld && (idx_q == {WIN_LOG2{1'b1}});
  assign fail    = win_end && !count_ok(int'(ones_nx), WIN_LOG2);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      ones_q  <= '0;
      alarm_q <= 1'b0;
    end else begin
      if (raw.vld) begin
        idx_q  <= idx_q + 1'b1;
        ones_q <= win_end ? '0 : ones_nx;
      end
      if (fail)     alarm_q <= 1'b1;
      else if (clr) alarm_q <= 1'b0;
    end
  end
endmodule

// File: rtl/trng_cond.sv
module trng_cond
  import trng_pkg::*;
#(
  parameter int NSRC     = 8,
  parameter int WIN_LOG2 = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sample_stb,
  input  logic [NSRC-1:0] src_in,
  input  logic            clear_alarm,
  output logic            out_valid,
  output logic            out_bit,
  output logic            alarm
);
  logic [NSRC-1:0] src_sync;
  raw_s            raw;
  logic            raw_vld;
  logic            vn_vld;
  logic            vn_bit;
  logic            win_end;
  logic            alarm_o;

  trng_sync #(.NSRC(NSRC)) u_sync (
    .clk(clk), .rst(rst), .d_in(src_in), .q_out(src_sync)
  );

  trng_sampler #(.NSRC(NSRC)) u_samp (
    .clk(clk), .rst(rst), .stb(sample_stb), .src_sync(src_sync), .raw(raw)
  );

  trng_debias u_vn (
    .clk(clk), .rst(rst), .raw(raw), .vn_vld(vn_vld), .vn_bit(vn_bit)
  );

  trng_health #(.WIN_LOG2(WIN_LOG2)) u_hm (
    .clk(clk), .rst(rst), .raw(raw), .clr(clear_alarm),
    .win_end(win_end), .alarm_q(alarm_o)
  );

  assign raw_vld   = raw.vld;
  assign out_valid = vn_vld && !alarm_o;
  assign out_bit   = vn_bit;
  assign alarm     = alarm_o;
endmodule

// File: rtl/trng_cond_chk.sv
module trng_cond_chk (
  input logic clk,
  input logic rst,
  input logic sample_stb,
  input logic clear_alarm,
  input logic raw_vld,
  input logic vn_vld,
  input logic win_end,
  input logic alarm
);
  // R2
  raw_from_stb_chk: assert property (@(posedge clk) disable iff (rst)
    raw_vld |-> $past(sample_stb));

  // R4
  vn_from_raw_chk: assert property (@(posedge clk) disable iff (rst)
    vn_vld |-> $past(raw_vld));

  // R3
  vn_not_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    vn_vld |=> !vn_vld);

  // R6
  alarm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (alarm && !clear_alarm) |=> alarm);

  // R5
  alarm_at_window_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm) |-> $past(win_end));
endmodule

bind trng_cond trng_cond_chk u_chk (
  .clk(clk), .rst(rst), .sample_stb(sample_stb), .clear_alarm(clear_alarm),
  .raw_vld(raw_vld), .vn_vld(vn_vld), .win_end(win_end), .alarm(alarm_o)
);

// File: tb/trng_cond_test.sv
module trng_cond_test;
  localparam int NS = 3;
  localparam int WL = 4;
  localparam int WIN = 1 << WL;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sample_stb = 1'b0;
  logic [NS-1:0] src_in = '0;
  logic          clear_alarm = 1'b0;
  logic          out_valid, out_bit, alarm;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  int  m_idx = 0, m_ones = 0;
  bit  m_alarm = 0, m_have = 0, m_first = 0;
  int  pat_ctr = 0;
  int  tol, mid;

  always #4 clk = ~clk;

  trng_cond #(.NSRC(NS), .WIN_LOG2(WL)) uut (
    .clk(clk), .rst(rst), .sample_stb(sample_stb), .src_in(src_in),
    .clear_alarm(clear_alarm), .out_valid(out_valid), .out_bit(out_bit),
    .alarm(alarm)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // one raw sample of value b; clr asserts clear_alarm on the edge that reports it
  task automatic put_bit(input bit b, input bit clr);
    logic [NS-1:0] p;
    bit vexp, bexp;
    p = NS'(pat_ctr);
    pat_ctr++;
    if ((^p) != b) p[0] = ~p[0];
    @(negedge clk) src_in = p;
    @(negedge clk);
    @(negedge clk) sample_stb = 1'b1;
    @(negedge clk) begin sample_stb = 1'b0; clear_alarm = clr; end
    @(negedge clk) clear_alarm = 1'b0;
    // model
    vexp = 0; bexp = 0;
    m_ones += b; m_idx++;
    if (m_idx == WIN) begin
      if (m_ones < mid - tol || m_ones > mid + tol) m_alarm = 1;
      else if (clr) m_alarm = 0;
      m_idx = 0; m_ones = 0;
    end else if (clr) m_alarm = 0;
    if (m_have) begin
      m_have = 0;
      if (m_first != b) begin vexp = 1; bexp = m_first; end
    end else begin
      m_have = 1; m_first = b;
    end
    chk("R5/R6 alarm", alarm, m_alarm);
    chk("R3/R4/R7 out_valid", out_valid, vexp && !m_alarm);
    if (vexp && !m_alarm) chk("R4 out_bit", out_bit, bexp);
  endtask

  task automatic put_window(input int k, input int w, input int clr_at);
    for (int i = 0; i < WIN; i++)
      put_bit(((i * 5 + w * 3) % WIN) < k, i == clr_at);
  endtask

  task automatic pulse_clear();
    @(negedge clk) clear_alarm = 1'b1;
    @(negedge clk) clear_alarm = 1'b0;
    m_alarm = 0;
    chk("R6 clear drops alarm", alarm, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    bit seq[16];
    tol = 0;
    while (tol * 10000 < 173 * WIN) tol++;
    mid = WIN / 2;
    seq = '{1,0, 0,1, 0,0, 1,1, 1,0, 1,0, 1,0, 0,1};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out_valid after reset", out_valid, 1'b0);
    chk("R1 alarm after reset", alarm, 1'b0);

    // directed pairs 10,01,00,11 and more: 8 ones in the first window
    for (int i = 0; i < 8; i++) put_bit(seq[i], 0);

    // R2: source activity without strobe changes nothing
    put_bit(1'b1, 0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk) src_in = NS'(i);
      chk("R2 no strobe no output", out_valid, 1'b0);
    end
    put_bit(1'b0, 0);               // completes pair 1,0 -> 1
    for (int i = 10; i < 16; i++) put_bit(seq[i], 0);

    put_window(9, 1, -1);           // upper edge, passes
    put_window(7, 2, -1);           // lower edge, passes
    put_window(10, 3, -1);          // R5 over, alarm
    put_window(8, 4, -1);           // R7 suppressed while alarmed
    pulse_clear();
    put_window(6, 5, WIN - 1);      // R6 set wins over clear at window end
    pulse_clear();
    put_window(16, 6, -1);          // all ones
    pulse_clear();
    put_window(0, 7, -1);           // all zeros
    pulse_clear();
    put_window(10, 8, 7);           // R8 mid-window clear, alarm still at 16th
    pulse_clear();
    put_window(8, 9, -1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule